// File: doc/BRIEF.md
# I2C Mode Register with Frame Bit Counter

This block is the mode register of an I2C controller together with the two small engines it steers: a frame bit counter and a reference clock prescaler. Software reaches the 8-bit register through a plain write strobe and a read bus that always shows the current value. The upper half sets the prescaler rate and decides whether the separate master/transmit mode bits may be written. The lower half shows the bits left in the current frame and lets software preload that count between frames.

The counter steps down on every sampled rising edge of SCL and is cleared by a start or repeated-start pulse from the bus condition detector. A 3-bit code covers frames of two to nine bits, with nine coded as zero, so a byte plus its acknowledge loads as zero. The counter field is guarded by a lock bit in the same write. The lock bit must be zero for the counter to take the new value, and it always reads back as one. The prescaler is free-running and gives a one-cycle enable at the system clock divided by a power of two.

Top module: `i2c_mode_reg`

## Requirements
- R1: After reset, rdata reads 0x18 (mode-write permit 0, clock select 1, lock bit shown as 1, count 000), bits_left is 9, mode_wr_ok is 0 and frame_done is 0.
- R2: Every write stores wdata[7] as the mode-write permit and wdata[6:4] as the clock select. rdata is {permit, select, 1, count} with the permit in bit 7 and the count in bits 2:0.
- R3: With clock select n, ref_en pulses high for one cycle every 2^n cycles, and is high in every cycle when n is 0. A write that changes the select restarts the prescaler, so the first pulse comes 2^n cycles after that write's clock edge.
- R4: Each scl_rise cycle with no start and no counter load lowers the count by one, modulo 8, so 000 steps to 111.
- R5: A start_det cycle sets the count to 000. This takes priority over a counter load and over scl_rise in the same cycle.
- R6: A write loads wdata[2:0] into the count only when wdata[3] is 0. With wdata[3] at 1 the count is unchanged. Bit 3 of rdata is always 1.
- R7: frame_done is high for exactly the one cycle after a counted scl_rise that takes the count from 001 to 000.
- R8: bits_left is 9 for count 000, and count+1 for counts 001 to 111.
- R9: mode_wr_ok equals the stored mode-write permit bit, and follows a write from the next cycle on.
- R10: A counter load and an scl_rise in the same cycle leave the loaded value, without a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read value |
| scl_rise | input | 1 | One-cycle pulse on a sampled SCL rising edge |
| start_det | input | 1 | One-cycle pulse on a start or repeated start |
| ref_en | output | 1 | Prescaled reference clock enable |
| bits_left | output | 4 | Bits remaining in the frame, 2 to 9 |
| frame_done | output | 1 | One-cycle frame completion pulse |
| mode_wr_ok | output | 1 | Write enable for the master/transmit mode bits |

## Verification
Every register update becomes visible on rdata, bits_left and mode_wr_ok in the cycle after the edge that takes the write, scl_rise or start_det. frame_done is registered and so appears in that same following cycle. ref_en is combinational from the prescaler count, so after a select change its first pulse is due 2^n cycles after the write edge. The bench drives inputs and compares all outputs at the falling edge, against a model that is advanced at each rising edge. This makes every result due in exactly the cycle the requirements name.

// File: rtl/i2c_mr_pkg.sv
package i2c_mr_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 3;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic             mode_we;
    logic [SEL_W-1:0] clk_sel;
    logic             cnt_lock;
    logic [CNT_W-1:0] cnt;
  } mr_view_t;

  // Frame length decoded from the 3-bit count code (000 means nine bits).
  function automatic logic [3:0] frame_bits(input logic [CNT_W-1:0] code);
    return (code == '0) ? 4'd9 : ({1'b0, code} + 4'd1);
  endfunction

  // Low-bit mask of the prescaler count for a given divide exponent.
  function automatic logic [15:0] div_mask(input logic [SEL_W-1:0] sel);
    return 16'((32'd1 << sel) - 32'd1);
  endfunction
endpackage

// File: rtl/i2c_mr_ctrl.sv
module i2c_mr_ctrl
  import i2c_mr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              mode_we,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  load_val,
  output logic              sel_change
);
  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(1);

  mr_view_t wv;
  assign wv = mr_view_t'(wdata);

  assign cnt_load   = wr_en && !wv.cnt_lock;
  assign load_val   = wv.cnt;
  assign sel_change = wr_en && (wv.clk_sel != clk_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_we <= 1'b0;
      clk_sel <= SEL_RST;
    end else if (wr_en) begin
      mode_we <= wv.mode_we;
      clk_sel <= wv.clk_sel;
    end
  end

  p_permit_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_we == $past(wdata[7])));
  p_select_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(clk_sel));
endmodule

// File: rtl/i2c_mr_bitcnt.sv
module i2c_mr_bitcnt
  import i2c_mr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             start_det,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             frame_done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic step;
  logic ends_frame;
  assign step       = scl_rise && !start_det && !cnt_load;
  assign ends_frame = step && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= ends_frame;
      if (start_det)     cnt <= '0;
      else if (cnt_load) cnt <= load_val;
      else if (step)     cnt <= cnt - LAST;
    end
  end

  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (cnt == '0));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == $past(cnt) - LAST));
  p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_det && !cnt_load && !scl_rise) |=> $stable(cnt));
  p_done_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (cnt == '0));
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !start_det) |=> (cnt == $past(load_val)));
endmodule

// File: rtl/i2c_mr_prescale.sv
module i2c_mr_prescale
  import i2c_mr_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             restart,
  output logic             ref_en
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  assign mask   = DIV_W'(div_mask(clk_sel));
  assign ref_en = ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else                   pre_q <= pre_q + DIV_W'(1);
  end

  p_undivided_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == '0) |-> ref_en);
  p_restart_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && ($countones(mask) >= 0)) |=> ((pre_q == '0) && (ref_en == (clk_sel == '0))));
endmodule

// File: rtl/i2c_mode_reg.sv
module i2c_mode_reg
  import i2c_mr_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       scl_rise,
  input  logic       start_det,
  output logic       ref_en,
  output logic [3:0] bits_left,
  output logic       frame_done,
  output logic       mode_wr_ok
);
  logic             mode_we;
  logic [SEL_W-1:0] clk_sel;
  logic             cnt_load;
  logic [CNT_W-1:0] load_val;
  logic             sel_change;
  logic [CNT_W-1:0] cnt;
  mr_view_t         rv;

  i2c_mr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .mode_we(mode_we), .clk_sel(clk_sel), .cnt_load(cnt_load),
    .load_val(load_val), .sel_change(sel_change)
  );

  i2c_mr_bitcnt u_cnt (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .start_det(start_det),
    .cnt_load(cnt_load), .load_val(load_val), .cnt(cnt), .frame_done(frame_done)
  );

  i2c_mr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .restart(sel_change), .ref_en(ref_en)
  );

  always_comb begin
    rv.mode_we  = mode_we;
    rv.clk_sel  = clk_sel;
    rv.cnt_lock = 1'b1;
    rv.cnt      = cnt;
  end

  assign rdata      = rv;
  assign bits_left  = frame_bits(cnt);
  assign mode_wr_ok = mode_we;

  p_bits_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left >= 4'd2) && (bits_left <= 4'd9));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: tb/i2c_mode_reg_test.sv
module i2c_mode_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       scl_rise = 1'b0;
  logic       start_det = 1'b0;
  logic [7:0] rdata;
  logic       ref_en;
  logic [3:0] bits_left;
  logic       frame_done;
  logic       mode_wr_ok;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_cnt = 0, m_mwe = 0, m_sel = 1, m_pre = 0, m_done = 0;

  always #4 clk = ~clk;

  i2c_mode_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .scl_rise(scl_rise), .start_det(start_det), .ref_en(ref_en),
    .bits_left(bits_left), .frame_done(frame_done), .mode_wr_ok(mode_wr_ok)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mwe = 0; m_sel = 1; m_pre = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (start_det) m_cnt = 0;
      else if (wr_en && !wdata[3]) m_cnt = int'(wdata[2:0]);
      else if (scl_rise) begin
        if (m_cnt == 1) m_done = 1;
        m_cnt = (m_cnt + 7) % 8;
      end
      if (wr_en && int'(wdata[6:4]) != m_sel) m_pre = 0;
      else m_pre = (m_pre + 1) % 128;
      if (wr_en) begin
        m_mwe = int'(wdata[7]);
        m_sel = int'(wdata[6:4]);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    return m_mwe * 128 + m_sel * 16 + 8 + m_cnt;
  endfunction

  // full per-cycle comparison against the model
  task automatic compare_all();
    int period;
    period = 1 << m_sel;
    chk("R2 rdata", int'(rdata), exp_rdata());
    chk("R8 bits_left", int'(bits_left), (m_cnt == 0) ? 9 : m_cnt + 1);
    chk("R3 ref_en", int'(ref_en), ((m_pre % period) == period - 1) ? 1 : 0);
    chk("R7 frame_done", int'(frame_done), m_done);
    chk("R9 mode_wr_ok", int'(mode_wr_ok), m_mwe);
  endtask

  // one cycle: apply inputs at the falling edge, compare at the next one
  task automatic cyc(input logic w, input logic [7:0] d, input logic s, input logic st);
    wr_en = w; wdata = d; scl_rise = s; start_det = st;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", int'(rdata), 8'h18);
    chk("R1 bits_left", int'(bits_left), 9);
    chk("R1 mode_wr_ok", int'(mode_wr_ok), 0);
    chk("R1 frame_done", int'(frame_done), 0);
    compare_all();
    idle(6);

    // R9 permit bit, R2 select, R6 lock bit set leaves count
    cyc(1'b1, 8'hA9, 1'b0, 1'b0);
    chk("R9 permit set", int'(mode_wr_ok), 1);
    chk("R6 locked write", int'(rdata[2:0]), 0);
    chk("R6 lock reads one", int'(rdata[3]), 1);
    idle(8);

    // R6 load 3 (4 bits), then R4 count down through a frame, R7 done
    cyc(1'b1, 8'h03, 1'b0, 1'b0);
    chk("R6 load", int'(rdata[2:0]), 3);
    chk("R9 permit cleared", int'(mode_wr_ok), 0);
    for (int i = 0; i < 3; i++) begin cyc(1'b0, 8'h00, 1'b1, 1'b0); idle(1); end
    chk("R4 reached zero", int'(bits_left), 9);
    // R4 wrap 000 -> 111
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R4 wrap", int'(rdata[2:0]), 7);

    // R5 start beats load and edge
    cyc(1'b1, 8'h05, 1'b1, 1'b1);
    chk("R5 start priority", int'(rdata[2:0]), 0);
    // R10 load beats edge
    cyc(1'b1, 8'h04, 1'b1, 1'b0);
    chk("R10 load over edge", int'(rdata[2:0]), 4);
    // R6 lock set with edge: plain step
    cyc(1'b1, 8'h0E, 1'b1, 1'b0);
    chk("R6 lock ignored", int'(rdata[2:0]), 3);

    // R3 select changes: first pulse 2^n cycles after the write edge
    for (int n = 0; n < 8; n++) begin
      cyc(1'b1, 8'({n[2:0], 4'b1000}), 1'b0, 1'b0);
      first = 0;
      for (int k = 1; k <= (1 << n); k++) begin
        if (ref_en && first == 0) first = k;
        if (k < (1 << n)) cyc(1'b0, 8'h00, 1'b0, 1'b0);
      end
      chk("R3 first pulse", first, 1 << n);
      idle(1 << n);
    end

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [7:0] d;
      w = ($urandom % 10) == 0;
      d = 8'($urandom);
      cyc(w, d, ($urandom % 3) == 0, ($urandom % 40) == 0);
    end
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule